// File: doc/BRIEF.md
# SPI Serial-Memory Read Sequencer

This block is an SPI master that fetches a run of bytes from a serial non-volatile memory (EEPROM or FRAM class). The host gives a start byte offset and a byte count. The block checks the request against the configured device size and shortens it if needed. It then splits the work into chip-select bursts. The largest burst length is a configuration input.

Each burst drops chip-select and shifts out a read opcode followed by a 1-, 2- or 3-byte address, most significant byte first. The block then clocks in data bytes and hands each one to the host on a valid/ready byte stream. While the host holds the stream, the serial clock stays idle. Some small parts have a ninth address bit. For these, the block can fold that bit into the opcode. The SPI link uses mode 0, and the serial clock is the system clock divided by a programmable ratio. The block ends a request with a one-cycle done pulse. A request it refuses gets a one-cycle error pulse instead.

Top module: `spi_mem_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done`, `err` and `rd_valid` are all 0.
- R2: Each burst starts with opcode byte 0x03, followed by `cfg_addr_bytes` address bytes (values 1, 2 or 3), most significant byte first. The value 0 is refused with an error pulse.
- R3: When `cfg_nine_bit` is 1 and the burst start offset is at least 2^(8×address bytes), the opcode becomes 0x0B (bit 3 set). The address bytes then carry only the low bits.
- R4: A start offset equal to or above `cfg_dev_size` is refused with an error pulse, and chip-select never falls for it.
- R5: If offset + count runs past `cfg_dev_size`, the count is cut to `cfg_dev_size` − offset. A count of 0 is refused, and so is a `cfg_max_chunk` of 0.
- R6: A request of N bytes is split into ceil(N / max_chunk) bursts. Each burst carries at most max_chunk bytes. Each burst address is the start offset plus the bytes already delivered.
- R7: SPI mode 0 is used. `spi_sck` is low whenever chip-select is high. `spi_mosi` changes only while `spi_sck` is low, and `spi_miso` is sampled on the rising edge.
- R8: Each high phase of `spi_sck` lasts `cfg_clk_div`+1 system clocks.
- R9: Between two bursts of one request, chip-select stays high for at least 4×(`cfg_clk_div`+1) system clocks (two serial clock periods).
- R10: Bytes appear on `rd_data` in ascending address order. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold.
- R11: `done` pulses for one cycle when the last byte is taken, and `busy` is 0 in that same cycle. A request presented while `busy` is 1 has no effect.
- R12: `err` pulses for one cycle, in the cycle after a refused request is presented, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_bytes | input | 2 | Address length in bytes (1..3) |
| cfg_nine_bit | input | 1 | Fold the ninth address bit into opcode bit 3 |
| cfg_dev_size | input | OFS_W+1 | Device size in bytes |
| cfg_max_chunk | input | CNT_W | Largest number of data bytes in one burst |
| cfg_clk_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_offset | input | OFS_W | Start byte offset |
| req_count | input | CNT_W | Bytes requested |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| err | output | 1 | One-cycle pulse for a refused request |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Host takes the byte |
| spi_sck | output | 1 | Serial clock (idle low) |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
A refused request raises `err` exactly one cycle after the accepting edge. The bench therefore reads `err` at the falling edge right after the request, and confirms it has cleared by the next falling edge. `done` rises on the same edge that passes the last byte, with `busy` already low. The bench polls at falling edges and checks both in that cycle. Serial-side timing is measured in system clocks by a bus-functional memory model: the length of each high phase of the serial clock, and the chip-select high time between bursts. Every received byte and every burst header is compared against queues the driver fills before the request starts.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_HDR,
    ST_DATA,
    ST_HOLD,
    ST_GAP
  } rd_state_t;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_A8BIT = 8'h08;
  localparam int unsigned GAP_TICKS = 4;
endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    en |=> (cnt <= div));
endmodule

// File: rtl/spi_rd_shift.sv
module spi_rd_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       active,
  output logic       fin,
  output logic [7:0] rx_byte
);
  logic [7:0] sh;
  logic [2:0] nbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      nbit    <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      active  <= 1'b0;
      fin     <= 1'b0;
      rx_byte <= '0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sck    <= 1'b0;
          sh     <= tx_byte;
          mosi   <= tx_byte[7];
          nbit   <= '0;
        end
      end else if (tick) begin
        if (!sck) begin
          sck <= 1'b1;
          sh  <= {sh[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (nbit == 3'd7) begin
            active  <= 1'b0;
            fin     <= 1'b1;
            rx_byte <= sh;
          end else begin
            nbit <= nbit + 3'd1;
            mosi <= sh[7];
          end
        end
      end
    end
  end

  a_r7_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
  a_r7_sck_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sck);
endmodule

// File: rtl/spi_rd_frame.sv
module spi_rd_frame #(
  parameter int unsigned OFS_W = 24
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       ab,
  input  logic             nine,
  input  logic [2:0]       idx,
  output logic [7:0]       byte_o
);
  import spi_rd_pkg::*;

  logic [31:0] ofs32;
  logic [7:0]  lane [4];
  logic        above;
  logic [1:0]  sel;

  assign ofs32 = 32'(ofs);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane[g] = ofs32[8*g +: 8];
  end

  assign above = |(ofs32 >> {ab, 3'b000});
  assign sel   = ab - idx[1:0];

  always_comb begin
    if (idx == 3'd0)
      byte_o = OPC_READ | ((nine && above) ? OPC_A8BIT : 8'h00);
    else
      byte_o = lane[sel];
  end
endmodule

// File: rtl/spi_mem_reader.sv
module spi_mem_reader #(
  parameter int unsigned OFS_W = 24,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_addr_bytes,
  input  logic             cfg_nine_bit,
  input  logic [OFS_W:0]   cfg_dev_size,
  input  logic [CNT_W-1:0] cfg_max_chunk,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic             req_valid,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [CNT_W-1:0] req_count,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  import spi_rd_pkg::*;

  localparam int unsigned SZ_W = OFS_W + 1;
  localparam int unsigned GC_W = DIV_W + 4;

  rd_state_t        state;
  logic [OFS_W-1:0] cur_ofs;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] burst_left;
  logic [2:0]       hdr_idx;
  logic [1:0]       ab_q;
  logic             nine_q;
  logic [CNT_W-1:0] chunk_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       gap_cnt;
  logic             sh_go;
  logic [7:0]       sh_tx;
  logic             sh_active;
  logic             sh_fin;
  logic [7:0]       sh_rx;
  logic             tick;
  logic [7:0]       frame_byte;

  // request screening
  logic [SZ_W-1:0]  room;
  logic [SZ_W-1:0]  cnt_ext;
  logic [CNT_W-1:0] clamped;
  logic             refuse;
  logic [CNT_W-1:0] burst_len;

  assign room    = cfg_dev_size - {1'b0, req_offset};
  assign cnt_ext = {{(SZ_W-CNT_W){1'b0}}, req_count};
  assign clamped = (cnt_ext > room) ? room[CNT_W-1:0] : req_count;
  assign refuse  = (cfg_addr_bytes == 2'd0) || (cfg_max_chunk == '0) ||
                   ({1'b0, req_offset} >= cfg_dev_size) || (req_count == '0);
  assign burst_len = (remain > chunk_q) ? chunk_q : remain;

  assign busy = (state != ST_IDLE);

  spi_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (sh_active || (state == ST_GAP)),
    .div  (div_q),
    .tick (tick)
  );

  spi_rd_frame #(.OFS_W(OFS_W)) u_frame (
    .ofs    (cur_ofs),
    .ab     (ab_q),
    .nine   (nine_q),
    .idx    (hdr_idx),
    .byte_o (frame_byte)
  );

  spi_rd_shift u_shift (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .start   (sh_go),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .active  (sh_active),
    .fin     (sh_fin),
    .rx_byte (sh_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_ofs    <= '0;
      remain     <= '0;
      burst_left <= '0;
      hdr_idx    <= '0;
      ab_q       <= '0;
      nine_q     <= 1'b0;
      chunk_q    <= '0;
      div_q      <= '0;
      gap_cnt    <= '0;
      sh_go      <= 1'b0;
      sh_tx      <= '0;
      spi_cs_n   <= 1'b1;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      sh_go <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (refuse) begin
              err <= 1'b1;
            end else begin
              cur_ofs <= req_offset;
              remain  <= clamped;
              ab_q    <= cfg_addr_bytes;
              nine_q  <= cfg_nine_bit;
              chunk_q <= cfg_max_chunk;
              div_q   <= cfg_clk_div;
              hdr_idx <= '0;
              state   <= ST_SEL;
            end
          end
        end
        ST_SEL: begin
          spi_cs_n   <= 1'b0;
          burst_left <= burst_len;
          sh_tx      <= frame_byte;
          sh_go      <= 1'b1;
          hdr_idx    <= 3'd1;
          state      <= ST_HDR;
        end
        ST_HDR: begin
          if (sh_fin) begin
            sh_go <= 1'b1;
            if (hdr_idx <= {1'b0, ab_q}) begin
              sh_tx   <= frame_byte;
              hdr_idx <= hdr_idx + 3'd1;
            end else begin
              sh_tx <= 8'h00;
              state <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (sh_fin) begin
            rd_data    <= sh_rx;
            rd_valid   <= 1'b1;
            burst_left <= burst_left - CNT_W'(1);
            remain     <= remain - CNT_W'(1);
            cur_ofs    <= cur_ofs + OFS_W'(1);
            state      <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            if (remain == '0) begin
              spi_cs_n <= 1'b1;
              done     <= 1'b1;
              state    <= ST_IDLE;
            end else if (burst_left == '0) begin
              spi_cs_n <= 1'b1;
              gap_cnt  <= '0;
              state    <= ST_GAP;
            end else begin
              sh_tx <= 8'h00;
              sh_go <= 1'b1;
              state <= ST_DATA;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            gap_cnt <= gap_cnt + 2'd1;
            if (gap_cnt == 2'(GAP_TICKS - 1)) begin
              hdr_idx <= '0;
              state   <= ST_SEL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker counter: cycles spent with chip-select released between bursts
  logic [GC_W-1:0] gap_cyc;
  always_ff @(posedge clk) begin
    if (rst)                  gap_cyc <= '0;
    else if (state == ST_GAP) gap_cyc <= gap_cyc + GC_W'(1);
    else                      gap_cyc <= '0;
  end

  a_r7_sck_idle_deselected: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  a_r2_valid_addr_len: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> (ab_q != 2'd0));
  a_r6_burst_bound: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> (burst_left <= chunk_q));
  a_r9_gap_length: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEL && $past(state) == ST_GAP) |->
      (gap_cyc >= ((GC_W'(div_q) + GC_W'(1)) << 2)));
  a_r10_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && spi_cs_n));
  a_r12_err_single: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  a_r4_err_no_select: assert property (@(posedge clk) disable iff (rst)
    err |-> (spi_cs_n && !busy));
endmodule

// File: tb/spi_mem_reader_test.sv
module spi_mem_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 24;
  localparam int CNT_W = 16;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cfg_addr_bytes = 2'd2;
  logic             cfg_nine_bit = 1'b0;
  logic [OFS_W:0]   cfg_dev_size = 25'd4096;
  logic [CNT_W-1:0] cfg_max_chunk = 16'd8;
  logic [DIV_W-1:0] cfg_clk_div = 8'd1;
  logic             req_valid = 1'b0;
  logic [OFS_W-1:0] req_offset = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic             busy, done, err, rd_valid, spi_sck, spi_cs_n, spi_mosi;
  logic [7:0]       rd_data;
  logic             rd_ready = 1'b1;
  logic             spi_miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int t_ab = 2, t_nine = 0, t_div = 1;
  bit stall = 0;
  bit armed = 0;
  int err_seen = 0;

  logic [7:0] exp_q [$];
  int bq_op [$];
  int bq_addr [$];
  int bq_n [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_mem_reader #(.OFS_W(OFS_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst),
    .cfg_addr_bytes(cfg_addr_bytes), .cfg_nine_bit(cfg_nine_bit),
    .cfg_dev_size(cfg_dev_size), .cfg_max_chunk(cfg_max_chunk),
    .cfg_clk_div(cfg_clk_div),
    .req_valid(req_valid), .req_offset(req_offset), .req_count(req_count),
    .busy(busy), .done(done), .err(err),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  function automatic logic [7:0] mem_at(int a);
    return 8'((a * 29) ^ (a >> 8) ^ 8'h5A);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // ready pattern for the host side
  always @(posedge clk) rd_ready <= stall ? (($urandom % 4) != 0) : 1'b1;

  always @(negedge clk) if (err) err_seen++;

  // scoreboard monitor (R10)
  bit hold_prev = 0;
  logic [7:0] hold_data;
  always @(negedge clk) begin
    if (hold_prev) begin
      check(rd_valid === 1'b1, "R10 valid held", int'(rd_valid), 1);
      check(rd_data === hold_data, "R10 data held", int'(rd_data), int'(hold_data));
    end
    hold_prev = rd_valid && !rd_ready;
    hold_data = rd_data;
    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected byte", int'(rd_data), -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rd_data === e, "R10 byte order/value", int'(rd_data), int'(e));
      end
    end
  end

  // R8: high phase length of the serial clock
  int hi_run = 0;
  always @(negedge clk) begin
    if (spi_sck === 1'b1) hi_run++;
    else if (hi_run > 0) begin
      check(hi_run == t_div + 1, "R8 sck high phase", hi_run, t_div + 1);
      hi_run = 0;
    end
  end

  // bus-functional serial memory
  int s_bits = 0;
  logic [7:0] s_sh = '0;
  logic [7:0] s_hdr [4];
  int s_addr = 0;
  int rise_cyc = 0;
  bit have_rise = 0;

  always @(negedge spi_cs_n) begin
    s_bits = 0;
    if (armed && have_rise)
      check(cyc - rise_cyc >= 4 * (t_div + 1), "R9 deselect gap",
            cyc - rise_cyc, 4 * (t_div + 1));
  end

  always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
    s_sh = {s_sh[6:0], spi_mosi};
    s_bits++;
    if (s_bits % 8 == 0 && s_bits <= 8 * (1 + t_ab))
      s_hdr[s_bits/8 - 1] = s_sh;
  end

  always @(negedge spi_sck) if (spi_cs_n === 1'b0 && s_bits >= 8 * (1 + t_ab)) begin
    int d;
    logic [7:0] b;
    if (s_bits == 8 * (1 + t_ab)) begin
      s_addr = 0;
      for (int k = 1; k <= t_ab; k++) s_addr = (s_addr << 8) | int'(s_hdr[k]);
      if (t_nine != 0 && s_hdr[0][3]) s_addr += (1 << (8 * t_ab));
    end
    d = s_bits - 8 * (1 + t_ab);
    b = mem_at(s_addr + d / 8);
    spi_miso = b[7 - d % 8];
  end

  always @(posedge spi_cs_n) if (armed) begin
    int nb;
    nb = (s_bits - 8 * (1 + t_ab)) / 8;
    rise_cyc = cyc;
    have_rise = 1;
    if (bq_op.size() == 0) begin
      check(0, "R6 unexpected burst", nb, 0);
    end else begin
      int eo, ea, en;
      eo = bq_op.pop_front();
      ea = bq_addr.pop_front();
      en = bq_n.pop_front();
      check(int'(s_hdr[0]) == eo, "R2/R3 opcode", int'(s_hdr[0]), eo);
      check(s_addr == ea, "R2/R6 burst address", s_addr, ea);
      check(nb == en, "R6 burst length", nb, en);
    end
  end

  // driver: good request, expected items go to the queues first
  task automatic run_read(int ab, int nine, int size, int ofs, int cnt,
                          int chunk, int div, bit stl, bit inject);
    int n, o, r, b, guard, e0;
    t_ab = ab; t_nine = nine; t_div = div; stall = stl;
    cfg_addr_bytes = 2'(ab); cfg_nine_bit = nine[0];
    cfg_dev_size = 25'(size); cfg_max_chunk = 16'(chunk); cfg_clk_div = 8'(div);
    n = (ofs + cnt > size) ? size - ofs : cnt;
    o = ofs; r = n;
    while (r > 0) begin
      b = (r > chunk) ? chunk : r;
      bq_op.push_back(3 | ((nine != 0 && o >= (1 << (8 * ab))) ? 8 : 0));
      bq_addr.push_back(o);
      bq_n.push_back(b);
      for (int i = 0; i < b; i++) exp_q.push_back(mem_at(o + i));
      o += b; r -= b;
    end
    have_rise = 0; armed = 1; e0 = err_seen;
    @(negedge clk);
    req_offset = 24'(ofs); req_count = 16'(cnt); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R11 busy after accept", int'(busy), 1);
    if (inject) begin
      repeat (20) @(negedge clk);
      req_offset = 24'd0; req_count = 16'd1; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    check(done === 1'b1, "R11 done raised", int'(done), 1);
    check(busy === 1'b0, "R11 idle with done", int'(busy), 0);
    @(negedge clk);
    check(done === 1'b0, "R11 done one cycle", int'(done), 0);
    check(exp_q.size() == 0, "R10 all bytes delivered", exp_q.size(), 0);
    check(bq_op.size() == 0, "R6 all bursts seen", bq_op.size(), 0);
    check(err_seen == e0, "R11 no error during run", err_seen - e0, 0);
    repeat (3) @(negedge clk);
    armed = 0;
    exp_q.delete(); bq_op.delete(); bq_addr.delete(); bq_n.delete();
  endtask

  // driver: request that must be refused
  task automatic run_reject(string req, int ab, int size, int ofs, int cnt, int chunk);
    cfg_addr_bytes = 2'(ab); cfg_dev_size = 25'(size); cfg_max_chunk = 16'(chunk);
    @(negedge clk);
    req_offset = 24'(ofs); req_count = 16'(cnt); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(err === 1'b1, {req, " error pulse"}, int'(err), 1);
    check(busy === 1'b0, {req, " stays idle"}, int'(busy), 0);
    check(spi_cs_n === 1'b1, {req, " no select"}, int'(spi_cs_n), 1);
    @(negedge clk);
    check(err === 1'b0, "R12 error one cycle", int'(err), 0);
    check(spi_cs_n === 1'b1, {req, " no select later"}, int'(spi_cs_n), 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(spi_cs_n === 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
    check(spi_sck === 1'b0, "R1 sck", int'(spi_sck), 0);
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(done === 1'b0 && err === 1'b0, "R1 pulses", int'(done) + int'(err), 0);
    check(rd_valid === 1'b0, "R1 rd_valid", int'(rd_valid), 0);

    // R2 R6 two-byte address, three bursts
    run_read(2, 0, 4096, 'h123, 20, 8, 1, 0, 0);
    // R3 nine-bit folding across the 256 boundary, host stalls (R10)
    run_read(1, 1, 512, 'hF8, 16, 8, 0, 1, 0);
    // R5 truncation at the end of the device
    run_read(1, 0, 256, 250, 20, 4, 2, 0, 0);
    // R2 three-byte address
    run_read(3, 0, 1 << 24, 'h012345, 5, 16, 3, 1, 0);
    // R5 last two bytes of a full 24-bit device
    run_read(3, 0, 1 << 24, 'hFFFFFE, 10, 3, 0, 0, 0);
    // R11 request while busy has no effect
    run_read(2, 0, 4096, 'h040, 12, 5, 1, 0, 1);

    // R4 R5 R2 R12 refused requests
    run_reject("R4 offset at size", 2, 4096, 4096, 4, 8);
    run_reject("R4 offset beyond size", 2, 4096, 5000, 4, 8);
    run_reject("R5 zero count", 2, 4096, 10, 0, 8);
    run_reject("R5 zero chunk", 2, 4096, 10, 4, 0);
    run_reject("R2 zero address length", 0, 4096, 10, 4, 8);

    // R12 a good request still works after refusals
    run_read(1, 0, 256, 0, 3, 2, 0, 0, 0);
    finish_run();
  end
endmodule